// File: doc/BRIEF.md
# Low-power clock mode sequencer

This block owns the clock-divider controls and the power-down controls around the clock tree of an audio subsystem. The crystal clock can pass through a halving stage, used when a double-rate crystal is fitted, and then through a deep divide-by-256 stage. Their output drives both the analog section and a clock multiplier. The halving stage simply follows a strap-like select input. The deep stage is only ever switched by an internal sequencer, which brings the rest of the system into a state where slowing the clock is harmless.

In the normal state, the multiplier setting and the two DAC sample values pass from their inputs to registered outputs. An enter pulse starts a fixed one-step-per-cycle sequence. The sequence captures the live DAC values and the multiplier setting, forces the multiplier to unity, powers down the analog drivers, zeroes both DAC samples, and powers down analog bias unless a quick resume was announced. It enables the deep divider last. An exit pulse undoes these steps in reverse. The final multiplier restore waits for a lock indication or a bounded timeout. The PLL, the analog circuits and the clock multiplexers are represented only by these register outputs and the lock status input.

Top module: `lpclk_seq`

## Requirements
- R1: After reset, all of these are 0: `div2_en_o`, `div256_en_o`, `drv_pdown_o`, `bias_pdown_o`, `busy_o`, `done_o`, `err_o`, `dac_l_o` and `dac_r_o`. `mult_o` holds MULT_RST (default 1).
- R2: In the normal state, one clock edge after they are sampled, `div2_en_o` equals `xtal_fast_i`, `mult_o` equals `mult_i`, and `dac_l_o`/`dac_r_o` equal `dac_l_i`/`dac_r_i`. `div2_en_o` follows `xtal_fast_i` in every state.
- R3: Number the edge that samples `enter_i` high in the normal state as edge 0. `mult_o` becomes MULT_ONE (1 = unity) at edge 1, `drv_pdown_o` rises at edge 2, both DAC outputs become 0 at edge 3, and `div256_en_o` rises at edge 5.
- R4: `div256_en_o` is never 1 unless `mult_o` is MULT_ONE, `drv_pdown_o` is 1 and both DAC outputs are 0.
- R5: `bias_pdown_o` rises at edge 4 of an entry only if `resume_soon_i` was 0 at edge 0. Otherwise it stays 0 for the whole low-power stay.
- R6: Number the edge that samples `exit_i` high in the low-power state as edge 0. `div256_en_o` falls at edge 0, `bias_pdown_o` is 0 from edge 1, the DAC outputs take the values captured at entry at edge 2, and `drv_pdown_o` falls at edge 3. The restored values do not depend on the DAC inputs at exit time.
- R7: After edge 3 of an exit, `mult_o` returns to the value captured at entry. This happens at the first later edge that samples `lock_i` high, or at edge 3+LOCK_TMO (default 16) if `lock_i` stays low.
- R8: `busy_o` is 1 while an entry or exit sequence runs, and 0 in the normal and low-power states.
- R9: `done_o` is a single-cycle pulse, raised on the edge that completes each entry (edge 5) and each exit. An exit pulse in the normal state is ignored and gives no `done_o`.
- R10: An enter pulse while `busy_o` is 1 sets `err_o`, which stays 1 until reset. The running sequence carries on unchanged.
- R11: An enter pulse in the low-power state, and an exit pulse during a sequence, are ignored: no state change, no `done_o`, no `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enter_i | input | 1 | Request pulse: enter low-power mode |
| exit_i | input | 1 | Request pulse: leave low-power mode |
| resume_soon_i | input | 1 | Sampled with enter: keep analog bias powered |
| xtal_fast_i | input | 1 | Double-rate crystal fitted: enable halving stage |
| mult_i | input | MULT_W | Multiplier setting requested in normal state |
| dac_l_i | input | DAC_W | Left DAC sample requested in normal state |
| dac_r_i | input | DAC_W | Right DAC sample requested in normal state |
| lock_i | input | 1 | Clock multiplier lock status |
| div2_en_o | output | 1 | Halving stage enable |
| div256_en_o | output | 1 | Divide-by-256 stage enable |
| mult_o | output | MULT_W | Multiplier setting register |
| drv_pdown_o | output | 1 | Analog driver power-down |
| bias_pdown_o | output | 1 | Analog bias power-down |
| dac_l_o | output | DAC_W | Left DAC sample register |
| dac_r_o | output | DAC_W | Right DAC sample register |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at sequence end |
| err_o | output | 1 | Sticky: enter requested while busy |

## Verification
The hardest case to reach is the multiplier restore at the end of an exit when lock never arrives. The bench holds `lock_i` low through a whole exit and checks `mult_o` on both sides of edge 3+LOCK_TMO. It then repeats the exit with lock already high, so that the restore happens one edge after the drivers are released. To show that restoring uses the captured values, the DAC inputs are changed while the block is in low power. A second enter is issued in the middle of an entry sequence, to set the error flag without disturbing the order of the steps.

// File: rtl/lpclk_pkg.sv
package lpclk_pkg;

    typedef enum logic [3:0] {
        ST_NORM,
        ST_E_MULT,
        ST_E_DRV,
        ST_E_ZERO,
        ST_E_BIAS,
        ST_E_DIV,
        ST_LOW,
        ST_X_BIAS,
        ST_X_DAC,
        ST_X_DRV,
        ST_X_LOCK
    } seq_state_e;

    typedef struct packed {
        logic div256;
        logic drv_pd;
        logic bias_pd;
        logic keep_bias;
        logic done;
        logic err;
    } seq_ctl_t;

endpackage

// File: rtl/lpclk_save.sv
module lpclk_save #(
    parameter int DAC_W    = 16,
    parameter int MULT_W   = 4,
    parameter int MULT_RST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [DAC_W-1:0]  dl_i,
    input  logic [DAC_W-1:0]  dr_i,
    input  logic [MULT_W-1:0] mult_i,
    output logic [DAC_W-1:0]  dl_o,
    output logic [DAC_W-1:0]  dr_o,
    output logic [MULT_W-1:0] mult_o
);

    typedef struct packed {
        logic [DAC_W-1:0]  dl;
        logic [DAC_W-1:0]  dr;
        logic [MULT_W-1:0] mult;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (cap_i) begin
            bank_d.dl   = dl_i;
            bank_d.dr   = dr_i;
            bank_d.mult = mult_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.dl   <= '0;
            bank_q.dr   <= '0;
            bank_q.mult <= MULT_W'(MULT_RST);
        end else begin
            bank_q <= bank_d;
        end
    end

    assign dl_o   = bank_q.dl;
    assign dr_o   = bank_q.dr;
    assign mult_o = bank_q.mult;

endmodule

// File: rtl/lpclk_lock_wait.sv
module lpclk_lock_wait #(
    parameter int LOCK_TMO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    input  logic lock_i,
    output logic fin_o
);

    localparam int CW = $clog2(LOCK_TMO + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_TMO - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign fin_o = run_i && (lock_i || (cnt_q == LAST));

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = '0;
        end else if (run_i && !fin_o) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/lpclk_seq.sv
module lpclk_seq
    import lpclk_pkg::*;
#(
    parameter int DAC_W    = 16,
    parameter int MULT_W   = 4,
    parameter int MULT_RST = 1,
    parameter int MULT_ONE = 1,
    parameter int LOCK_TMO = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_i,
    input  logic              exit_i,
    input  logic              resume_soon_i,
    input  logic              xtal_fast_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic [DAC_W-1:0]  dac_l_i,
    input  logic [DAC_W-1:0]  dac_r_i,
    input  logic              lock_i,
    output logic              div2_en_o,
    output logic              div256_en_o,
    output logic [MULT_W-1:0] mult_o,
    output logic              drv_pdown_o,
    output logic              bias_pdown_o,
    output logic [DAC_W-1:0]  dac_l_o,
    output logic [DAC_W-1:0]  dac_r_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);

    localparam logic [MULT_W-1:0] UNITY = MULT_W'(MULT_ONE);

    typedef struct packed {
        seq_state_e        st;
        seq_ctl_t          ctl;
        logic              div2;
        logic [MULT_W-1:0] mult;
        logic [DAC_W-1:0]  dl;
        logic [DAC_W-1:0]  dr;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;

    logic              cap;
    logic              tmr_start;
    logic              tmr_run;
    logic              tmr_fin;
    logic              busy;
    logic [DAC_W-1:0]  sav_dl;
    logic [DAC_W-1:0]  sav_dr;
    logic [MULT_W-1:0] sav_mult;

    lpclk_save #(
        .DAC_W    (DAC_W),
        .MULT_W   (MULT_W),
        .MULT_RST (MULT_RST)
    ) u_save (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap),
        .dl_i   (dac_l_i),
        .dr_i   (dac_r_i),
        .mult_i (mult_i),
        .dl_o   (sav_dl),
        .dr_o   (sav_dr),
        .mult_o (sav_mult)
    );

    lpclk_lock_wait #(
        .LOCK_TMO (LOCK_TMO)
    ) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .run_i   (tmr_run),
        .lock_i  (lock_i),
        .fin_o   (tmr_fin)
    );

    assign busy = (seq_q.st != ST_NORM) && (seq_q.st != ST_LOW);

    always_comb begin
        seq_d          = seq_q;
        seq_d.ctl.done = 1'b0;
        seq_d.div2     = xtal_fast_i;
        cap            = 1'b0;
        tmr_start      = 1'b0;
        tmr_run        = 1'b0;

        if (enter_i && busy) begin
            seq_d.ctl.err = 1'b1;
        end

        unique case (seq_q.st)
            ST_NORM: begin
                seq_d.mult = mult_i;
                seq_d.dl   = dac_l_i;
                seq_d.dr   = dac_r_i;
                if (enter_i) begin
                    cap                 = 1'b1;
                    seq_d.ctl.keep_bias = resume_soon_i;
                    seq_d.st            = ST_E_MULT;
                end
            end
            ST_E_MULT: begin
                seq_d.mult = UNITY;
                seq_d.st   = ST_E_DRV;
            end
            ST_E_DRV: begin
                seq_d.ctl.drv_pd = 1'b1;
                seq_d.st         = ST_E_ZERO;
            end
            ST_E_ZERO: begin
                seq_d.dl = '0;
                seq_d.dr = '0;
                seq_d.st = ST_E_BIAS;
            end
            ST_E_BIAS: begin
                seq_d.ctl.bias_pd = !seq_q.ctl.keep_bias;
                seq_d.st          = ST_E_DIV;
            end
            ST_E_DIV: begin
                seq_d.ctl.div256 = 1'b1;
                seq_d.ctl.done   = 1'b1;
                seq_d.st         = ST_LOW;
            end
            ST_LOW: begin
                if (exit_i) begin
                    seq_d.ctl.div256 = 1'b0;
                    seq_d.st         = ST_X_BIAS;
                end
            end
            ST_X_BIAS: begin
                seq_d.ctl.bias_pd = 1'b0;
                seq_d.st          = ST_X_DAC;
            end
            ST_X_DAC: begin
                seq_d.dl = sav_dl;
                seq_d.dr = sav_dr;
                seq_d.st = ST_X_DRV;
            end
            ST_X_DRV: begin
                seq_d.ctl.drv_pd = 1'b0;
                tmr_start        = 1'b1;
                seq_d.st         = ST_X_LOCK;
            end
            ST_X_LOCK: begin
                tmr_run = 1'b1;
                if (tmr_fin) begin
                    seq_d.mult     = sav_mult;
                    seq_d.ctl.done = 1'b1;
                    seq_d.st       = ST_NORM;
                end
            end
            default: begin
                seq_d.st = ST_NORM;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_NORM;
            seq_q.ctl  <= '0;
            seq_q.div2 <= 1'b0;
            seq_q.mult <= MULT_W'(MULT_RST);
            seq_q.dl   <= '0;
            seq_q.dr   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign div2_en_o    = seq_q.div2;
    assign div256_en_o  = seq_q.ctl.div256;
    assign mult_o       = seq_q.mult;
    assign drv_pdown_o  = seq_q.ctl.drv_pd;
    assign bias_pdown_o = seq_q.ctl.bias_pd;
    assign dac_l_o      = seq_q.dl;
    assign dac_r_o      = seq_q.dr;
    assign busy_o       = busy;
    assign done_o       = seq_q.ctl.done;
    assign err_o        = seq_q.ctl.err;

endmodule

// File: rtl/lpclk_seq_chk.sv
module lpclk_seq_chk #(
    parameter int DAC_W    = 16,
    parameter int MULT_W   = 4,
    parameter int MULT_ONE = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              div256_en_o,
    input logic [MULT_W-1:0] mult_o,
    input logic              drv_pdown_o,
    input logic              bias_pdown_o,
    input logic [DAC_W-1:0]  dac_l_o,
    input logic [DAC_W-1:0]  dac_r_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o
);

    // R4
    div_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div256_en_o |-> (mult_o == MULT_W'(MULT_ONE)));

    // R4
    div_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div256_en_o |-> drv_pdown_o);

    // R4
    div_dac_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div256_en_o |-> (dac_l_o == '0 && dac_r_o == '0));

    // R3
    drv_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div256_en_o) |-> $past(drv_pdown_o));

    // R5
    bias_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bias_pdown_o |-> drv_pdown_o);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

bind lpclk_seq lpclk_seq_chk #(
    .DAC_W    (DAC_W),
    .MULT_W   (MULT_W),
    .MULT_ONE (MULT_ONE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .div256_en_o  (div256_en_o),
    .mult_o       (mult_o),
    .drv_pdown_o  (drv_pdown_o),
    .bias_pdown_o (bias_pdown_o),
    .dac_l_o      (dac_l_o),
    .dac_r_o      (dac_r_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/lpclk_seq_bench.sv
module lpclk_seq_bench;

    localparam int DW  = 16;
    localparam int MW  = 4;
    localparam int TMO = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enter_i = 1'b0;
    logic          exit_i = 1'b0;
    logic          resume_soon_i = 1'b0;
    logic          xtal_fast_i = 1'b0;
    logic [MW-1:0] mult_i = 4'd1;
    logic [DW-1:0] dac_l_i = '0;
    logic [DW-1:0] dac_r_i = '0;
    logic          lock_i = 1'b0;
    logic          div2_en_o;
    logic          div256_en_o;
    logic [MW-1:0] mult_o;
    logic          drv_pdown_o;
    logic          bias_pdown_o;
    logic [DW-1:0] dac_l_o;
    logic [DW-1:0] dac_r_o;
    logic          busy_o;
    logic          done_o;
    logic          err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    lpclk_seq #(
        .DAC_W    (DW),
        .MULT_W   (MW),
        .LOCK_TMO (TMO)
    ) u_lpclk_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .enter_i       (enter_i),
        .exit_i        (exit_i),
        .resume_soon_i (resume_soon_i),
        .xtal_fast_i   (xtal_fast_i),
        .mult_i        (mult_i),
        .dac_l_i       (dac_l_i),
        .dac_r_i       (dac_r_i),
        .lock_i        (lock_i),
        .div2_en_o     (div2_en_o),
        .div256_en_o   (div256_en_o),
        .mult_o        (mult_o),
        .drv_pdown_o   (drv_pdown_o),
        .bias_pdown_o  (bias_pdown_o),
        .dac_l_o       (dac_l_o),
        .dac_r_o       (dac_r_o),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .err_o         (err_o)
    );

    // {xtal, mult, dac_l, dac_r}
    localparam int VW = 1 + MW + 2 * DW;
    localparam logic [VW-1:0] VEC [6] = '{
        {1'b1, 4'd3, 16'h1234, 16'hABCD},
        {1'b0, 4'd7, 16'hFFFF, 16'h0000},
        {1'b1, 4'd0, 16'h0001, 16'h8000},
        {1'b0, 4'd15, 16'h5A5A, 16'hA5A5},
        {1'b1, 4'd1, 16'h0000, 16'hFFFF},
        {1'b0, 4'd5, 16'h00C3, 16'h3C00}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick();
        // R1 reset state
        chk("R1", "div2", {31'd0, div2_en_o}, 0);
        chk("R1", "div256", {31'd0, div256_en_o}, 0);
        chk("R1", "mult", {28'd0, mult_o}, 1);
        chk("R1", "pdowns", {30'd0, drv_pdown_o, bias_pdown_o}, 0);
        chk("R1", "flags", {29'd0, busy_o, done_o, err_o}, 0);
        chk("R1", "dac", {dac_l_o, dac_r_o}, 0);
        rst_n = 1'b1;
        tick();

        // R2 pass-through in normal state
        for (int i = 0; i < 6; i++) begin
            {xtal_fast_i, mult_i, dac_l_i, dac_r_i} = VEC[i];
            tick();
            chk("R2", "passthru", {div2_en_o, mult_o, dac_l_o[10:0], dac_r_o},
                {VEC[i][VW-1:VW-1-MW], VEC[i][DW+10:DW], VEC[i][DW-1:0]});
            chk("R2", "dac_l", {16'd0, dac_l_o}, {16'd0, VEC[i][2*DW-1:DW]});
        end

        // R9 exit in normal state is ignored
        exit_i = 1'b1;
        tick();
        exit_i = 1'b0;
        chk("R9", "no done on idle exit", {30'd0, done_o, busy_o}, 0);
        tick();
        chk("R9", "still idle", {31'd0, done_o}, 0);

        // R3 entry with bias power-down (resume_soon low)
        mult_i = 4'd5; dac_l_i = 16'h1111; dac_r_i = 16'h2222;
        resume_soon_i = 1'b0;
        enter_i = 1'b1;
        tick();                         // edge 0
        enter_i = 1'b0;
        chk("R8", "busy after enter", {31'd0, busy_o}, 1);
        chk("R3", "mult before step", {28'd0, mult_o}, 5);
        exit_i = 1'b1;                  // R11 exit during sequence ignored
        tick();                         // edge 1
        exit_i = 1'b0;
        chk("R3", "mult unity e1", {28'd0, mult_o}, 1);
        chk("R3", "drv not yet e1", {31'd0, drv_pdown_o}, 0);
        tick();                         // edge 2
        chk("R3", "drv down e2", {31'd0, drv_pdown_o}, 1);
        chk("R3", "dac held e2", {dac_l_o, dac_r_o}, 32'h11112222);
        tick();                         // edge 3
        chk("R3", "dac zero e3", {dac_l_o, dac_r_o}, 0);
        chk("R5", "bias not yet e3", {31'd0, bias_pdown_o}, 0);
        tick();                         // edge 4
        chk("R5", "bias down e4", {31'd0, bias_pdown_o}, 1);
        chk("R3", "div off e4", {31'd0, div256_en_o}, 0);
        tick();                         // edge 5
        chk("R3", "div on e5", {31'd0, div256_en_o}, 1);
        chk("R9", "done e5", {30'd0, done_o, busy_o}, 2);
        chk("R11", "exit in seq ignored", {31'd0, err_o}, 0);
        tick();
        chk("R9", "done one cycle", {31'd0, done_o}, 0);

        // R11 enter in low-power ignored; inputs move
        dac_l_i = 16'h9999; dac_r_i = 16'h8888; mult_i = 4'd9;
        enter_i = 1'b1;
        tick();
        enter_i = 1'b0;
        tick();
        chk("R11", "enter in low ignored",
            {26'd0, busy_o, done_o, err_o, div256_en_o, drv_pdown_o, bias_pdown_o}, 32'h7);
        chk("R11", "outputs frozen", {dac_l_o, dac_r_o}, 0);

        // R6 exit, no lock -> timeout
        lock_i = 1'b0;
        exit_i = 1'b1;
        tick();                         // edge 0
        exit_i = 1'b0;
        chk("R6", "div off x0", {30'd0, div256_en_o, busy_o}, 1);
        chk("R6", "bias still x0", {31'd0, bias_pdown_o}, 1);
        tick();                         // edge 1
        chk("R6", "bias up x1", {31'd0, bias_pdown_o}, 0);
        chk("R6", "dac zero x1", {dac_l_o, dac_r_o}, 0);
        tick();                         // edge 2
        chk("R6", "dac restored x2", {dac_l_o, dac_r_o}, 32'h11112222);
        chk("R6", "drv still x2", {31'd0, drv_pdown_o}, 1);
        tick();                         // edge 3
        chk("R6", "drv up x3", {31'd0, drv_pdown_o}, 0);
        for (int k = 4; k < 3 + TMO; k++) tick();
        chk("R7", "mult waiting", {28'd0, mult_o}, 1);
        chk("R8", "busy while waiting", {30'd0, busy_o, done_o}, 2);
        tick();                         // edge 3+TMO
        chk("R7", "mult restored on timeout", {28'd0, mult_o}, 5);
        chk("R9", "exit done", {30'd0, busy_o, done_o}, 1);
        tick();
        chk("R2", "follows input again", {28'd0, mult_o}, 9);
        chk("R2", "dac follows again", {dac_l_o, dac_r_o}, 32'h99998888);

        // R5 entry keeping bias; R10 enter during sequence
        mult_i = 4'd12; dac_l_i = 16'h0F0F; dac_r_i = 16'hF0F0;
        resume_soon_i = 1'b1;
        enter_i = 1'b1;
        tick();                         // edge 0
        resume_soon_i = 1'b0;
        tick();                         // edge 1, enter still high -> error
        enter_i = 1'b0;
        chk("R10", "err set", {31'd0, err_o}, 1);
        tick(); tick(); tick();         // edges 2..4
        chk("R5", "bias kept e4", {31'd0, bias_pdown_o}, 0);
        chk("R10", "sequence intact e4", {dac_l_o, dac_r_o}, 0);
        tick();                         // edge 5
        chk("R10", "done despite err", {30'd0, div256_en_o, done_o}, 3);
        chk("R5", "bias kept low", {31'd0, bias_pdown_o}, 0);

        // R7 exit with lock already high
        lock_i = 1'b1;
        dac_l_i = 16'h7777;
        exit_i = 1'b1;
        tick();
        exit_i = 1'b0;
        tick(); tick();
        chk("R6", "restore ignores inputs", {dac_l_o, dac_r_o}, 32'h0F0FF0F0);
        tick();                         // edge 3
        chk("R7", "mult unity x3", {28'd0, mult_o}, 1);
        tick();                         // edge 4
        chk("R7", "mult restored on lock", {28'd0, mult_o}, 12);
        chk("R9", "done on lock", {31'd0, done_o}, 1);
        chk("R10", "err sticky", {31'd0, err_o}, 1);
        lock_i = 1'b0;

        // R1 reset clears error
        rst_n = 1'b0;
        tick();
        chk("R1", "err cleared", {31'd0, err_o}, 0);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule